// File: doc/BRIEF.md
# Microcoded 16-bit Processor Datapath

This block is the execution datapath of a small 16-bit processor. Every cycle a microsequencer outside the block drives its register selects, source selects, ALU opcode and load strobes. The block holds a 32-entry register file, two operand latches feeding an ALU, a 15-bit program counter, a data-out register and an address register. It drives a 16-bit data bus, a 15-bit address bus and a pair of zero flags. Instruction decode, memory and sequencing live elsewhere.

Register select A is both the write address and the first read port. Select B drives the second read port. Each register write takes its value from one of four sources. The program counter takes its next value from one of three sources. Only the strobes the microcode raises in a given cycle have any effect.

Top module: `cpu_dp_core`

## Requirements
- R1: While rst_ni is low, and asynchronously, data_o resets to 0x0000. The program counter and the address register reset to 0x7FFE, so addr_o reads 0x7FFE. Both operand latches and all registers reset to 0x0000.
- R2: When wr_en_i is high, the register at sel_a_i is written on the rising edge. The source is set by wr_src_i: 00 takes data_i, 01 takes the program counter, 10 takes the ALU result, 11 takes the value read at sel_b_i. Reads are combinational, so the new value appears on the read ports in the next cycle.
- R3: Register 0 is an ordinary writable register. With wr_en_i low, no register changes.
- R4: When pc_ld_i is high, the program counter takes a value chosen by pc_src_i. 00 increments it, and 0x7FFF wraps to 0x0000. 01 takes data_i[14:0]. 10 takes bits [14:0] of read port A. 11 holds the value. When pc_ld_i is low, the program counter holds.
- R5: areg_ld_i loads bits [14:0] of read port A into the address register. addr_o shows the address register when addr_sel_i is 1 and the program counter when it is 0.
- R6: dout_ld_i loads read port A into the data-out register, which drives data_o. With the strobe low, data_o holds.
- R7: opa_ld_i loads read port A into operand latch A. opb_ld_i loads read port B into operand latch B. A latch whose strobe is low keeps its value.
- R8: The ALU result depends on alu_op_i: 0 passes A, 1 gives A+1, 2 gives A-1, 3 gives A+B, 4 gives A-B, 5 gives A AND B, 6 gives A OR B, 7 gives A XOR B, 8 gives NOT A, 9 shifts A left by one, and 10 shifts A right by one, logically. Other codes give 0x0000. Arithmetic wraps modulo 2^16.
- R9: zero_o is 1 exactly when the value on read port A is 0x0000. nzero_o is its complement.
- R10: A program counter written into a register is zero-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_a_i | input | 5 | Write address and read port A select |
| sel_b_i | input | 5 | Read port B select |
| wr_src_i | input | 2 | Register write source |
| alu_op_i | input | 4 | ALU opcode |
| wr_en_i | input | 1 | Register write enable |
| pc_src_i | input | 2 | Program counter next-value source |
| pc_ld_i | input | 1 | Program counter load strobe |
| dout_ld_i | input | 1 | Data-out register load strobe |
| areg_ld_i | input | 1 | Address register load strobe |
| opa_ld_i | input | 1 | Operand latch A load strobe |
| opb_ld_i | input | 1 | Operand latch B load strobe |
| addr_sel_i | input | 1 | Address bus source: 1 address register, 0 program counter |
| data_i | input | 16 | External input data |
| zero_o | output | 1 | Read port A equals zero |
| nzero_o | output | 1 | Read port A is non-zero |
| data_o | output | 16 | Data-out register |
| addr_o | output | 15 | Address bus |

## Verification
The bench builds the block with its default parameters: 16-bit data, a 15-bit address and 32 registers. With these values the program counter's reset value of 0x7FFE can be observed directly. One load of 0x7FFF followed by an increment tests the wrap to zero. Because the data width is one bit wider than the address width, truncation shows up when 0xF0F0 becomes 0x70F0, and zero-extension shows up when a program counter value is written back into a register. The small register count also lets the tests use register 0 and several high-numbered registers side by side.

// File: rtl/cpu_dp_pkg.sv
package cpu_dp_pkg;

  typedef enum logic [1:0] {
    WR_EXT   = 2'b00,
    WR_PC    = 2'b01,
    WR_ALU   = 2'b10,
    WR_PORTB = 2'b11
  } wr_src_e;

  typedef enum logic [1:0] {
    PC_INC   = 2'b00,
    PC_EXT   = 2'b01,
    PC_PORTA = 2'b10,
    PC_HOLD  = 2'b11
  } pc_src_e;

  typedef enum logic [3:0] {
    ALU_PASS = 4'd0,
    ALU_INC  = 4'd1,
    ALU_DEC  = 4'd2,
    ALU_ADD  = 4'd3,
    ALU_SUB  = 4'd4,
    ALU_AND  = 4'd5,
    ALU_OR   = 4'd6,
    ALU_XOR  = 4'd7,
    ALU_NOT  = 4'd8,
    ALU_SHL  = 4'd9,
    ALU_SHR  = 4'd10
  } alu_op_e;

endpackage

// File: rtl/cpu_dp_regfile.sv
module cpu_dp_regfile #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int SEL_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_a_i,
  input  logic [SEL_W-1:0]  sel_b_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  wr_hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_dec
    assign wr_hit[i] = we_i && (sel_a_i == SEL_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_hit[i]) mem_q[i] <= wdata_i;
      end
    end
  end

  assign rd_a_o = mem_q[sel_a_i];
  assign rd_b_o = mem_q[sel_b_i];

endmodule

// File: rtl/cpu_dp_alu.sv
module cpu_dp_alu
  import cpu_dp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    case (op_i)
      ALU_PASS: res_o = a_i;
      ALU_INC:  res_o = a_i + ONE;
      ALU_DEC:  res_o = a_i - ONE;
      ALU_ADD:  res_o = a_i + b_i;
      ALU_SUB:  res_o = a_i - b_i;
      ALU_AND:  res_o = a_i & b_i;
      ALU_OR:   res_o = a_i | b_i;
      ALU_XOR:  res_o = a_i ^ b_i;
      ALU_NOT:  res_o = ~a_i;
      ALU_SHL:  res_o = {a_i[DATA_W-2:0], 1'b0};
      ALU_SHR:  res_o = {1'b0, a_i[DATA_W-1:1]};
      default:  res_o = '0;
    endcase
  end

endmodule

// File: rtl/cpu_dp_pc.sv
module cpu_dp_pc
  import cpu_dp_pkg::*;
#(
  parameter int                ADDR_W    = 15,
  parameter logic [ADDR_W-1:0] RESET_VAL = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [1:0]        src_i,
  input  logic [ADDR_W-1:0] ext_i,
  input  logic [ADDR_W-1:0] porta_i,
  output logic [ADDR_W-1:0] pc_o
);

  logic [ADDR_W-1:0] pc_q, pc_d;

  always_comb begin
    case (src_i)
      PC_INC:   pc_d = pc_q + ADDR_W'(1);
      PC_EXT:   pc_d = ext_i;
      PC_PORTA: pc_d = porta_i;
      default:  pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pc_q <= RESET_VAL;
    else if (ld_i) pc_q <= pc_d;
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/cpu_dp_core.sv
module cpu_dp_core
  import cpu_dp_pkg::*;
#(
  parameter int                DATA_W     = 16,
  parameter int                ADDR_W     = 15,
  parameter int                REGS       = 32,
  parameter logic [ADDR_W-1:0] ADDR_RESET = 15'h7FFE,
  localparam int               SEL_W      = $clog2(REGS),
  localparam int               PAD_W      = DATA_W - ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sel_a_i,
  input  logic [SEL_W-1:0]  sel_b_i,
  input  logic [1:0]        wr_src_i,
  input  logic [3:0]        alu_op_i,
  input  logic              wr_en_i,
  input  logic [1:0]        pc_src_i,
  input  logic              pc_ld_i,
  input  logic              dout_ld_i,
  input  logic              areg_ld_i,
  input  logic              opa_ld_i,
  input  logic              opb_ld_i,
  input  logic              addr_sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              zero_o,
  output logic              nzero_o,
  output logic [DATA_W-1:0] data_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic [DATA_W-1:0] rd_a, rd_b, wdata, alu_res;
  logic [DATA_W-1:0] opa_q, opb_q, dout_q;
  logic [ADDR_W-1:0] areg_q, pc_q;

  always_comb begin
    case (wr_src_i)
      WR_EXT:  wdata = data_i;
      WR_PC:   wdata = {{PAD_W{1'b0}}, pc_q};
      WR_ALU:  wdata = alu_res;
      default: wdata = rd_b;
    endcase
  end

  cpu_dp_regfile #(.DATA_W(DATA_W), .DEPTH(REGS)) i_regfile (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i),
    .sel_a_i (sel_a_i),
    .sel_b_i (sel_b_i),
    .wdata_i (wdata),
    .rd_a_o  (rd_a),
    .rd_b_o  (rd_b)
  );

  cpu_dp_alu #(.DATA_W(DATA_W)) i_alu (
    .op_i  (alu_op_i),
    .a_i   (opa_q),
    .b_i   (opb_q),
    .res_o (alu_res)
  );

  cpu_dp_pc #(.ADDR_W(ADDR_W), .RESET_VAL(ADDR_RESET)) i_pc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (pc_ld_i),
    .src_i   (pc_src_i),
    .ext_i   (data_i[ADDR_W-1:0]),
    .porta_i (rd_a[ADDR_W-1:0]),
    .pc_o    (pc_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opa_q  <= '0;
      opb_q  <= '0;
      dout_q <= '0;
      areg_q <= ADDR_RESET;
    end else begin
      if (opa_ld_i)  opa_q  <= rd_a;
      if (opb_ld_i)  opb_q  <= rd_b;
      if (dout_ld_i) dout_q <= rd_a;
      if (areg_ld_i) areg_q <= rd_a[ADDR_W-1:0];
    end
  end

  assign zero_o  = (rd_a == '0);
  assign nzero_o = ~zero_o;
  assign data_o  = dout_q;
  assign addr_o  = addr_sel_i ? areg_q : pc_q;

endmodule

// File: rtl/cpu_dp_checker.sv
module cpu_dp_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 15,
  parameter int SEL_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SEL_W-1:0]  sel_a_i,
  input logic [1:0]        wr_src_i,
  input logic              wr_en_i,
  input logic [1:0]        pc_src_i,
  input logic              pc_ld_i,
  input logic              dout_ld_i,
  input logic              opa_ld_i,
  input logic              addr_sel_i,
  input logic [DATA_W-1:0] data_i,
  input logic              zero_o,
  input logic [DATA_W-1:0] data_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [ADDR_W-1:0] pc_i,
  input logic [DATA_W-1:0] rd_a_i,
  input logic [DATA_W-1:0] opa_i
);

  AST_ZERO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o == (rd_a_i == '0)); // R9

  AST_EXT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_src_i == 2'b00) ##1 (sel_a_i == $past(sel_a_i)) |-> rd_a_i == $past(data_i)); // R2

  AST_DOUT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_ld_i |=> data_o == $past(rd_a_i)); // R6

  AST_DOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dout_ld_i |=> $stable(data_o)); // R6

  AST_PC_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_ld_i && pc_src_i == 2'b00) |=> pc_i == $past(pc_i) + 1'b1); // R4

  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pc_ld_i || pc_src_i == 2'b11) |=> $stable(pc_i)); // R4

  AST_ADDR_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_sel_i |-> addr_o == pc_i); // R5

  AST_OPA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !opa_ld_i |=> $stable(opa_i)); // R7

endmodule

bind cpu_dp_core cpu_dp_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_a_i    (sel_a_i),
  .wr_src_i   (wr_src_i),
  .wr_en_i    (wr_en_i),
  .pc_src_i   (pc_src_i),
  .pc_ld_i    (pc_ld_i),
  .dout_ld_i  (dout_ld_i),
  .opa_ld_i   (opa_ld_i),
  .addr_sel_i (addr_sel_i),
  .data_i     (data_i),
  .zero_o     (zero_o),
  .data_o     (data_o),
  .addr_o     (addr_o),
  .pc_i       (pc_q),
  .rd_a_i     (rd_a),
  .opa_i      (opa_q)
);

// File: tb/test_cpu_dp_core.sv
`timescale 1ns/1ps
module test_cpu_dp_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  sel_a = '0, sel_b = '0;
  logic [1:0]  wr_src = '0, pc_src = '0;
  logic [3:0]  alu_op = '0;
  logic        wr_en = 0, pc_ld = 0, dout_ld = 0, areg_ld = 0;
  logic        opa_ld = 0, opb_ld = 0, addr_sel = 0;
  logic [15:0] data = '0;
  logic        zero, nzero;
  logic [15:0] dout;
  logic [14:0] addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cpu_dp_core i_cpu_dp_core (
    .clk_i(clk), .rst_ni(rst_n), .sel_a_i(sel_a), .sel_b_i(sel_b),
    .wr_src_i(wr_src), .alu_op_i(alu_op), .wr_en_i(wr_en),
    .pc_src_i(pc_src), .pc_ld_i(pc_ld), .dout_ld_i(dout_ld),
    .areg_ld_i(areg_ld), .opa_ld_i(opa_ld), .opb_ld_i(opb_ld),
    .addr_sel_i(addr_sel), .data_i(data), .zero_o(zero), .nzero_o(nzero),
    .data_o(dout), .addr_o(addr)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; pc_ld = 0; dout_ld = 0; areg_ld = 0; opa_ld = 0; opb_ld = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic wr_ext(logic [4:0] s, logic [15:0] v);
    sel_a = s; wr_src = 2'b00; data = v; wr_en = 1; tick();
  endtask

  task automatic rd_dout(logic [4:0] s);
    sel_a = s; dout_ld = 1; tick();
  endtask

  task automatic pc_load(logic [1:0] src, logic [15:0] v);
    pc_src = src; data = v; pc_ld = 1; tick();
  endtask

  task automatic t_reset();
    chk("R1 data_o", dout, 16'h0000);
    chk("R1 addr_o", {1'b0, addr}, 16'h7FFE);
    chk("R9 zero after reset", {15'b0, zero}, 16'h1);
    chk("R9 nzero after reset", {15'b0, nzero}, 16'h0);
    wr_ext(5'd5, 16'hFFFF);
    alu_op = 4'd0; sel_a = 5'd5; wr_src = 2'b10; wr_en = 1; tick();
    rd_dout(5'd5);
    chk("R1 operand A reset", dout, 16'h0000);
  endtask

  task automatic t_write_src();
    wr_ext(5'd1, 16'hF0F0);
    rd_dout(5'd1);
    chk("R2 ext write", dout, 16'hF0F0);
    sel_a = 5'd3; sel_b = 5'd1; wr_src = 2'b11; wr_en = 1; tick();
    rd_dout(5'd3);
    chk("R2 port B copy", dout, 16'hF0F0);
    rd_dout(5'd4);
    chk("R6 data_o reloads", dout, 16'h0000);
  endtask

  task automatic t_reg0();
    wr_ext(5'd0, 16'hDEAD);
    rd_dout(5'd0);
    chk("R3 reg0 writable", dout, 16'hDEAD);
    sel_a = 5'd0; wr_src = 2'b00; data = 16'h1111; wr_en = 0; tick();
    rd_dout(5'd0);
    chk("R3 no write with wr_en low", dout, 16'hDEAD);
    sel_a = 5'd1; tick(); #1;
    chk("R6 data_o holds", dout, 16'hDEAD);
  endtask

  task automatic t_addr();
    sel_a = 5'd1; areg_ld = 1; tick();
    addr_sel = 1; #1;
    chk("R5 address reg truncated", {1'b0, addr}, 16'h70F0);
    addr_sel = 0; #1;
    chk("R5 address shows PC", {1'b0, addr}, 16'h7FFE);
    wr_ext(5'd1, 16'h1234);
    addr_sel = 1; #1;
    chk("R5 address reg holds", {1'b0, addr}, 16'h70F0);
    addr_sel = 0;
  endtask

  task automatic t_pc();
    pc_load(2'b01, 16'hA1B2);
    chk("R4 ext load", {1'b0, addr}, 16'h21B2);
    pc_load(2'b00, 16'h0000);
    chk("R4 increment", {1'b0, addr}, 16'h21B3);
    pc_src = 2'b01; data = 16'h1234; pc_ld = 0; tick();
    chk("R4 hold with pc_ld low", {1'b0, addr}, 16'h21B3);
    pc_load(2'b11, 16'h4321);
    chk("R4 hold source", {1'b0, addr}, 16'h21B3);
    sel_a = 5'd0;
    pc_load(2'b10, 16'h0000);
    chk("R4 port A load", {1'b0, addr}, 16'h5EAD);
    pc_load(2'b01, 16'hFFFF);
    pc_load(2'b00, 16'h0000);
    chk("R4 increment wraps", {1'b0, addr}, 16'h0000);
  endtask

  task automatic t_pc_to_reg();
    pc_load(2'b01, 16'h2000);
    sel_a = 5'd11; wr_src = 2'b01; wr_en = 1; tick();
    rd_dout(5'd11);
    chk("R10 PC to reg", dout, 16'h2000);
    pc_load(2'b01, 16'hFFFF);
    sel_a = 5'd11; wr_src = 2'b01; wr_en = 1; tick();
    rd_dout(5'd11);
    chk("R10 PC zero-extended", dout, 16'h7FFF);
  endtask

  task automatic alu_case(string req, logic [3:0] op, logic [15:0] a,
                          logic [15:0] b, logic [15:0] exp);
    wr_ext(5'd20, a);
    wr_ext(5'd21, b);
    sel_a = 5'd20; sel_b = 5'd21; opa_ld = 1; opb_ld = 1; tick();
    alu_op = op; sel_a = 5'd22; wr_src = 2'b10; wr_en = 1; tick();
    rd_dout(5'd22);
    chk(req, dout, exp);
  endtask

  task automatic t_alu();
    alu_case("R8 pass",  4'd0,  16'h4567, 16'h0000, 16'h4567);
    alu_case("R8 inc",   4'd1,  16'h001F, 16'h0000, 16'h0020);
    alu_case("R8 dec",   4'd2,  16'h1000, 16'h0000, 16'h0FFF);
    alu_case("R8 add",   4'd3,  16'h0111, 16'h0F21, 16'h1032);
    alu_case("R8 sub",   4'd4,  16'h7321, 16'h6421, 16'h0F00);
    alu_case("R8 and",   4'd5,  16'h0FA6, 16'hFA84, 16'h0A84);
    alu_case("R8 or",    4'd6,  16'h0101, 16'h0011, 16'h0111);
    alu_case("R8 xor",   4'd7,  16'h0101, 16'h0011, 16'h0110);
    alu_case("R8 not",   4'd8,  16'h0A0C, 16'h0000, 16'hF5F3);
    alu_case("R8 shl",   4'd9,  16'h7310, 16'h0000, 16'hE620);
    alu_case("R8 shr",   4'd10, 16'hC426, 16'h0000, 16'h6213);
    alu_case("R8 unused code", 4'd13, 16'h1234, 16'h5678, 16'h0000);
    alu_case("R8 add wraps", 4'd3, 16'hFFFF, 16'h0002, 16'h0001);
    alu_case("R8 dec wraps", 4'd2, 16'h0000, 16'h0000, 16'hFFFF);
  endtask

  task automatic t_opnd_hold();
    alu_case("R7 setup", 4'd4, 16'h1357, 16'h0007, 16'h1350);
    wr_ext(5'd20, 16'hFFFF);
    wr_ext(5'd21, 16'h0001);
    alu_op = 4'd4; sel_a = 5'd22; wr_src = 2'b10; wr_en = 1; tick();
    rd_dout(5'd22);
    chk("R7 latches hold", dout, 16'h1350);
    sel_b = 5'd21; opb_ld = 1; tick();
    alu_op = 4'd4; sel_a = 5'd22; wr_src = 2'b10; wr_en = 1; tick();
    rd_dout(5'd22);
    chk("R7 only B reloads", dout, 16'h1356);
  endtask

  task automatic t_zero();
    wr_ext(5'd12, 16'h0000);
    wr_ext(5'd13, 16'h0001);
    sel_a = 5'd12; #1;
    chk("R9 zero on zero", {15'b0, zero}, 16'h1);
    chk("R9 nzero on zero", {15'b0, nzero}, 16'h0);
    sel_a = 5'd13; #1;
    chk("R9 zero on nonzero", {15'b0, zero}, 16'h0);
    chk("R9 nzero on nonzero", {15'b0, nzero}, 16'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_src();
    t_reg0();
    t_addr();
    t_pc();
    t_pc_to_reg();
    t_alu();
    t_opnd_hold();
    t_zero();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule